// File: doc/BRIEF.md
# Self-Steering Multistage Processor-to-Memory Network

This block connects N requesting processors to N memory modules through a chain of log2(N) switching columns. Each column holds N/2 two-by-two switching elements, and the columns are joined by perfect-shuffle wiring. A request carries the index of its target memory module. Each column reads one bit of that index and steers the request with it, starting with the most significant bit. The network needs no central arbiter. For N=8 it has three columns and twelve elements.

When two requests at one element want the same output, the request on the element's upper input goes through and the other is dropped. The dropped processor sees a one-cycle reject pulse and may send the request again. A memory module that is not ready also rejects the request that reaches it. The network between the request ports and the result registers is combinational. Every result appears one clock edge after the request is sampled.

Top module: `mdr_net`

## Requirements
- R1: All outputs are registered. A request present at a rising edge produces its results right after that edge. During reset, and after a cycle with no valid request, every output is zero.
- R2: A granted request from source s with destination d drives mem_valid[d], puts s on the mem_src field of output d and puts its payload on the mem_data field of output d. Fields of port i sit at bits i*W upward, where W is the field width.
- R3: Requests that do not collide at any element all pass in the same cycle. Examples for N=8 are identity, reversal (d = 7-s) and cyclic shift (d = s+1 mod 8).
- R4: Column k steers with destination bit log2(N)-1-k. Bit value 0 selects the element's upper output and 1 selects the lower output. Before each column, line i moves to line rotate-left(i). Element e takes lines 2e (upper) and 2e+1 (lower). On a conflict, the upper input wins and the lower request is dropped.
- R5: Each source with a valid request gets exactly one of req_ready or req_reject in the next cycle. A source without a valid request gets neither.
- R6: No two granted requests share an output. The number of set mem_valid bits equals the number of set req_ready bits.
- R7: A request that reaches output d while mem_ready[d] is low is rejected, and mem_valid[d] stays low.
- R8: A rejected source that sends the same request again is granted once the request no longer collides.
- R9: req_ready and req_reject are one-cycle pulses. They clear in the cycle after a source withdraws its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per processor |
| req_dest | input | N_PORTS*log2(N_PORTS) | Destination module index per processor |
| req_data | input | N_PORTS*DATA_W | Payload per processor |
| req_ready | output | N_PORTS | Pulse: the request was delivered |
| req_reject | output | N_PORTS | Pulse: the request was dropped and may be retried |
| mem_ready | input | N_PORTS | Memory module can take a request this cycle |
| mem_valid | output | N_PORTS | A request is delivered to this module |
| mem_data | output | N_PORTS*DATA_W | Delivered payload per module |
| mem_src | output | N_PORTS*log2(N_PORTS) | Source index of the delivered request |

## Verification
Full permutations (identity, reversal, cyclic shift) show that paths which never meet all pass together and land at the right module. These patterns would catch wrong shuffle wiring or a wrong bit order. All sources aiming at one module give a collision at every column, with exactly one survivor. Pairs built to meet only in the first, second or last column show that the upper input wins at that point, and one pair with distinct destinations shows internal blocking. A partial mem_ready mask, a retry after a reject and a withdrawn request cover the memory-side refusal, reissue and pulse width.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
    // Perfect shuffle: rotate a line index of aw bits left by one place.
    function automatic int rotl_idx(input int idx, input int aw);
        int mask;
        mask = (1 << aw) - 1;
        return ((idx << 1) | (idx >> (aw - 1))) & mask;
    endfunction
endpackage

// File: rtl/mdr_switch.sv
// 2x2 switching element: passes or exchanges its two inputs according to one
// destination bit; on a clash the upper input keeps the output.
module mdr_switch #(
    parameter int AW    = 3,
    parameter int DW    = 8,
    parameter int STEER = 0,
    localparam int PW   = 1 + AW + AW + DW
) (
    input  logic [PW-1:0] up_i,
    input  logic [PW-1:0] lo_i,
    output logic [PW-1:0] up_o,
    output logic [PW-1:0] lo_o,
    output logic          drop_o,
    output logic [AW-1:0] drop_src_o
);
    logic up_v, lo_v, up_bit, lo_bit;

    assign up_v       = up_i[PW-1];
    assign lo_v       = lo_i[PW-1];
    assign up_bit     = up_i[DW + STEER];
    assign lo_bit     = lo_i[DW + STEER];
    assign drop_src_o = lo_i[DW + AW +: AW];

    always_comb begin
        up_o   = '0;
        lo_o   = '0;
        drop_o = 1'b0;
        if (up_v) begin
            if (up_bit) lo_o = up_i;
            else        up_o = up_i;
        end
        if (lo_v) begin
            if (up_v && (up_bit == lo_bit)) drop_o = 1'b1;
            else if (lo_bit)                lo_o   = lo_i;
            else                            up_o   = lo_i;
        end
    end
endmodule

// File: rtl/mdr_stage.sv
// One column: perfect-shuffle wiring followed by N/2 switching elements.
module mdr_stage #(
    parameter int NP    = 8,
    parameter int DW    = 8,
    parameter int STAGE = 0,
    localparam int AW   = $clog2(NP),
    localparam int PW   = 1 + AW + AW + DW,
    localparam int NSW  = NP / 2
) (
    input  logic [NP*PW-1:0] in_pkts,
    output logic [NP*PW-1:0] out_pkts,
    output logic [NP-1:0]    drop_vec
);
    logic [PW-1:0] shuf [NP];
    logic [NSW-1:0] sw_drop;
    logic [AW-1:0]  sw_src [NSW];

    for (genvar i = 0; i < NP; i++) begin : g_shuf
        localparam int DST = mdr_pkg::rotl_idx(i, AW);
        assign shuf[DST] = in_pkts[i*PW +: PW];
    end

    for (genvar s = 0; s < NSW; s++) begin : g_sw
        mdr_switch #(
            .AW   (AW),
            .DW   (DW),
            .STEER(AW - 1 - STAGE)
        ) u_sw (
            .up_i      (shuf[2*s]),
            .lo_i      (shuf[2*s+1]),
            .up_o      (out_pkts[(2*s)*PW +: PW]),
            .lo_o      (out_pkts[(2*s+1)*PW +: PW]),
            .drop_o    (sw_drop[s]),
            .drop_src_o(sw_src[s])
        );
    end

    always_comb begin
        drop_vec = '0;
        for (int s = 0; s < NSW; s++) begin
            if (sw_drop[s]) drop_vec[sw_src[s]] = 1'b1;
        end
    end
endmodule

// File: rtl/mdr_net.sv
// Destination-steered multistage network with registered grant/reject outputs.
module mdr_net #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    localparam int AW     = $clog2(N_PORTS),
    localparam int PW     = 1 + AW + AW + DATA_W,
    localparam int NS     = AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PORTS-1:0]      req_valid,
    input  logic [N_PORTS*AW-1:0]   req_dest,
    input  logic [N_PORTS*DATA_W-1:0] req_data,
    output logic [N_PORTS-1:0]      req_ready,
    output logic [N_PORTS-1:0]      req_reject,
    input  logic [N_PORTS-1:0]      mem_ready,
    output logic [N_PORTS-1:0]      mem_valid,
    output logic [N_PORTS*DATA_W-1:0] mem_data,
    output logic [N_PORTS*AW-1:0]   mem_src
);
    typedef struct packed {
        logic [N_PORTS-1:0]        grant;
        logic [N_PORTS-1:0]        reject;
        logic [N_PORTS-1:0]        mvalid;
        logic [N_PORTS*DATA_W-1:0] mdata;
        logic [N_PORTS*AW-1:0]     msrc;
    } net_state_t;

    net_state_t state_d, state_q;

    logic [N_PORTS*PW-1:0] chain [NS+1];
    logic [N_PORTS-1:0]    drops [NS];

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        localparam logic [AW-1:0] SRC_ID = AW'(i);
        assign chain[0][i*PW +: PW] = {req_valid[i], SRC_ID,
                                       req_dest[i*AW +: AW],
                                       req_data[i*DATA_W +: DATA_W]};
    end

    for (genvar k = 0; k < NS; k++) begin : g_stage
        mdr_stage #(
            .NP   (N_PORTS),
            .DW   (DATA_W),
            .STAGE(k)
        ) u_stage (
            .in_pkts (chain[k]),
            .out_pkts(chain[k+1]),
            .drop_vec(drops[k])
        );
    end

    always_comb begin
        logic [PW-1:0] pkt;
        logic [AW-1:0] src;
        state_d = '0;
        for (int k = 0; k < NS; k++) state_d.reject |= drops[k];
        for (int j = 0; j < N_PORTS; j++) begin
            pkt = chain[NS][j*PW +: PW];
            src = pkt[DATA_W + AW +: AW];
            if (pkt[PW-1]) begin
                if (mem_ready[j] && (pkt[DATA_W +: AW] == AW'(j))) begin
                    state_d.mvalid[j]                 = 1'b1;
                    state_d.mdata[j*DATA_W +: DATA_W] = pkt[DATA_W-1:0];
                    state_d.msrc[j*AW +: AW]          = src;
                    state_d.grant[src]                = 1'b1;
                end else begin
                    state_d.reject[src] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_ready  = state_q.grant;
    assign req_reject = state_q.reject;
    assign mem_valid  = state_q.mvalid;
    assign mem_data   = state_q.mdata;
    assign mem_src    = state_q.msrc;
endmodule

// File: rtl/mdr_net_chk.sv
module mdr_net_chk #(
    parameter int N_PORTS = 8,
    localparam int AW     = $clog2(N_PORTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_PORTS-1:0]    req_valid,
    input logic [N_PORTS*AW-1:0] req_dest,
    input logic [N_PORTS-1:0]    req_ready,
    input logic [N_PORTS-1:0]    req_reject,
    input logic [N_PORTS-1:0]    mem_ready,
    input logic [N_PORTS-1:0]    mem_valid,
    input logic [N_PORTS*AW-1:0] mem_src
);
    logic                  armed;
    logic [N_PORTS-1:0]    prev_valid;
    logic [N_PORTS*AW-1:0] prev_dest;
    logic [N_PORTS-1:0]    prev_mready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            prev_valid  <= '0;
            prev_dest   <= '0;
            prev_mready <= '0;
        end else begin
            armed       <= 1'b1;
            prev_valid  <= req_valid;
            prev_dest   <= req_dest;
            prev_mready <= mem_ready;
        end
    end

    AST_READY_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & req_reject) == '0); // R5

    AST_EVERY_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((req_ready | req_reject) == prev_valid)); // R5

    AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mem_valid) == $countones(req_ready)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && prev_valid == '0) |-> (mem_valid == '0 && req_reject == '0)); // R1

    for (genvar j = 0; j < N_PORTS; j++) begin : g_out
        logic [AW-1:0] who;
        assign who = mem_src[j*AW +: AW];

        AST_DEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && mem_valid[j]) |-> (req_ready[who] &&
                                         prev_dest[who*AW +: AW] == AW'(j))); // R2

        AST_MEM_READY_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && mem_valid[j]) |-> prev_mready[j]); // R7
    end
endmodule

bind mdr_net mdr_net_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .req_ready (req_ready),
    .req_reject(req_reject),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_src   (mem_src)
);

// File: tb/tb_mdr_net.sv
`timescale 1ns/1ps
module tb_mdr_net;
    localparam int NP = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid = '0;
    logic [NP*AW-1:0]  req_dest = '0;
    logic [NP*DW-1:0]  req_data = '0;
    logic [NP-1:0]     req_ready, req_reject;
    logic [NP-1:0]     mem_ready = '1;
    logic [NP-1:0]     mem_valid;
    logic [NP*DW-1:0]  mem_data;
    logic [NP*AW-1:0]  mem_src;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mdr_net #(.N_PORTS(NP), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dest(req_dest), .req_data(req_data),
        .req_ready(req_ready), .req_reject(req_reject),
        .mem_ready(mem_ready), .mem_valid(mem_valid),
        .mem_data(mem_data), .mem_src(mem_src)
    );

    typedef struct packed {
        logic [7:0]  valid;
        logic [23:0] dest;
        logic [7:0]  mready;
        logic [7:0]  grant;
        logic [7:0]  reject;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 24'o76543210, 8'hFF, 8'hFF, 8'h00},  // R3 identity
        '{8'hFF, 24'o00000000, 8'hFF, 8'h01, 8'hFE},  // R4 all to module 0
        '{8'hFF, 24'o01234567, 8'hFF, 8'hFF, 8'h00},  // R3 reversal
        '{8'hFF, 24'o07654321, 8'hFF, 8'hFF, 8'h00},  // R3 cyclic shift
        '{8'h05, 24'o00000100, 8'hFF, 8'h01, 8'h04},  // R4 clash in column 1
        '{8'h22, 24'o00700040, 8'hFF, 8'h02, 8'h20},  // R4 clash in column 0
        '{8'h00, 24'o00000000, 8'hFF, 8'h00, 8'h00},  // R1 idle
        '{8'hFF, 24'o76543210, 8'hF0, 8'hF0, 8'h0F},  // R7 partial mem_ready
        '{8'h0C, 24'o00005500, 8'hFF, 8'h04, 8'h08}   // R4 clash in column 2
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive after a falling edge; results are sampled at the next falling edge.
    task automatic apply(input logic [7:0] v, input logic [23:0] d,
                         input logic [7:0] mr, input logic [3:0] tag);
        req_valid = v;
        req_dest  = d;
        mem_ready = mr;
        for (int i = 0; i < NP; i++) req_data[i*DW +: DW] = {4'(i), tag};
        @(negedge clk);
    endtask

    task automatic check_outputs(input logic [7:0] eg, input logic [7:0] er,
                                 input string req);
        logic [NP-1:0] emv;
        emv = '0;
        check(req_ready == eg, {req, " req_ready"}, 64'(req_ready), 64'(eg));
        check(req_reject == er, {req, " req_reject"}, 64'(req_reject), 64'(er));
        for (int i = 0; i < NP; i++) begin
            if (eg[i]) begin
                logic [AW-1:0] d;
                d = req_dest[i*AW +: AW];
                emv[d] = 1'b1;
                check(mem_src[d*AW +: AW] == AW'(i), "R2 mem_src",
                      64'(mem_src[d*AW +: AW]), 64'(i));
                check(mem_data[d*DW +: DW] == req_data[i*DW +: DW], "R2 mem_data",
                      64'(mem_data[d*DW +: DW]), 64'(req_data[i*DW +: DW]));
            end
        end
        check(mem_valid == emv, "R6 mem_valid", 64'(mem_valid), 64'(emv));
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 0 && req_reject == 0 && mem_valid == 0, "R1 reset",
              64'({req_ready, req_reject, mem_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v].valid, VEC[v].dest, VEC[v].mready, 4'(v));
            check_outputs(VEC[v].grant, VEC[v].reject, $sformatf("R4/R5 vec%0d", v));
        end

        // R8: source 2 lost to source 0 on distinct targets; reissue alone
        apply(8'h05, 24'o00000100, 8'hFF, 4'hA);
        check(req_reject == 8'h04, "R8 first try", 64'(req_reject), 64'h04);
        apply(8'h04, 24'o00000100, 8'hFF, 4'hB);
        check_outputs(8'h04, 8'h00, "R8 retry");

        // R9: withdraw after grant; pulses clear
        apply(8'hFF, 24'o76543210, 8'hFF, 4'hC);
        check(req_ready == 8'hFF, "R9 granted", 64'(req_ready), 64'hFF);
        apply(8'h00, 24'o76543210, 8'hFF, 4'hD);
        check(req_ready == 0 && req_reject == 0 && mem_valid == 0, "R9 cleared",
              64'({req_ready, req_reject, mem_valid}), 64'(0));

        // R7: all modules refuse; every request rejected
        apply(8'hFF, 24'o01234567, 8'h00, 4'hE);
        check_outputs(8'h00, 8'hFF, "R7 none ready");

        // R1: outputs change only after the edge that samples the request
        req_valid = 8'h01;
        req_dest  = '0;
        mem_ready = '1;
        #1;
        check(req_ready == 0, "R1 no early output", 64'(req_ready), 64'h0);
        @(negedge clk);
        check(req_ready == 8'h01, "R1 one edge later", 64'(req_ready), 64'h01);
        req_valid = '0;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule